// File: doc/BRIEF.md
# Guarded Station Parameter Store

This block sits between a host bus and a small byte-wide parameter RAM that holds a station's own addresses and other medium-access settings. Each host request carries an address, a write flag, write data and a strobe. The block decides in the request cycle whether the access may go ahead. In stopped operation every access is accepted. In running operation an access is accepted only when the transmitter is in one of a few quiet states and four control bits are set to the right values.

An accepted write updates one RAM byte. An accepted read returns the byte one cycle later. A refused access changes nothing in the RAM. A refused read still completes one cycle later, but it returns zero. Any refused access raises a sticky command-error flag, which the host clears with a write-one-to-clear strobe.

The long and short station addresses live at fixed byte offsets. They are presented continuously on two outputs so that address-matching logic elsewhere can use them without going through the host port. The transmitter state, the mode and the control bits come from elsewhere and are plain inputs here.

Top module: `parm_access_guard`

## Requirements
- R1: When `run_mode` is 0, every request is accepted, whatever the values of `tx_state` and the control bits.
- R2: When `run_mode` is 1, a request can be accepted only if `tx_state` is 3'd0, 3'd1 or 3'd3 (the transmitter states T0, T1 and T3). The codes 3'd2 and 3'd4 to 3'd7 cause a refusal.
- R3: When `run_mode` is 1, a request can be accepted only if `opt_itc` and `opt_irr` are both 1.
- R4: When `run_mode` is 1, a request can be accepted only if `fn_clm` and `fn_bcn` are both 0.
- R5: A refused write leaves every RAM byte unchanged. An accepted write stores `host_wdata` at `host_addr`, and the new value is visible from the next cycle.
- R6: A read request (`host_req`=1, `host_we`=0) gives `host_rvalid`=1 in the next cycle. In that same cycle `host_rdata` carries the addressed byte if the read was accepted, or zero if it was refused. Whenever `host_rvalid` is 0, `host_rdata` is zero.
- R7: A refused request sets `cmd_err` to 1 in the next cycle. The flag then stays at 1 until it is cleared.
- R8: When `err_clr` is 1 and no refusal occurs in the same cycle, `cmd_err` goes to 0 in the next cycle. When a clear and a refusal occur in the same cycle, `cmd_err` is 1 afterwards.
- R9: `long_addr` is the concatenation of bytes 0x40 to 0x45, with byte 0x40 as the most significant. `short_addr` is bytes 0x46 and 0x47, with byte 0x46 as the most significant.
- R10: After reset, every RAM byte is zero, and `cmd_err`, `host_rvalid` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (7) | Byte address in the parameter space |
| host_wdata | input | DATA_W (8) | Write data |
| host_rdata | output | DATA_W (8) | Read data, valid together with `host_rvalid` |
| host_rvalid | output | 1 | Read completion, one cycle after the read request |
| run_mode | input | 1 | 0 = stopped operation, 1 = running operation |
| tx_state | input | 3 | Encoded transmitter state |
| opt_itc | input | 1 | Option control bit that must be 1 for running access |
| opt_irr | input | 1 | Option control bit that must be 1 for running access |
| fn_clm | input | 1 | Function bit that must be 0 for running access |
| fn_bcn | input | 1 | Function bit that must be 0 for running access |
| err_clr | input | 1 | Write-one-to-clear strobe for `cmd_err` |
| cmd_err | output | 1 | Sticky command-error flag |
| long_addr | output | 6*DATA_W (48) | Long station address |
| short_addr | output | 2*DATA_W (16) | Short station address |

## Verification
The bench builds the block with its default parameters: a 7-bit address, 8-bit data, and the station address window based at 0x40. With these values the whole 128-byte space, including the top byte 0x7F, is reachable from the bench, and the window sits at the offsets that address-matching logic expects. All eight transmitter state codes are driven in running mode, so each one is seen to be accepted or refused. A random phase mixes window and non-window addresses with changing control bits, to exercise refusals that land between accepted writes.

// File: rtl/pag_pkg.sv
package pag_pkg;

  localparam logic [2:0] TX_T0 = 3'd0;
  localparam logic [2:0] TX_T1 = 3'd1;
  localparam logic [2:0] TX_T3 = 3'd3;

  typedef struct packed {
    logic itc;
    logic irr;
    logic clm;
    logic bcn;
  } ctl_bits_t;

  // transmitter states in which running-mode access is open
  function automatic logic tx_state_open(input logic [2:0] st);
    return (st == TX_T0) || (st == TX_T1) || (st == TX_T3);
  endfunction

  function automatic logic ctl_bits_open(input ctl_bits_t c);
    return c.itc && c.irr && !c.clm && !c.bcn;
  endfunction

  function automatic logic access_permitted(input logic run,
                                            input logic [2:0] st,
                                            input ctl_bits_t c);
    return !run || (tx_state_open(st) && ctl_bits_open(c));
  endfunction

endpackage

// File: rtl/pag_permit.sv
module pag_permit
  import pag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic       run_mode,
  input  logic [2:0] tx_state,
  input  ctl_bits_t  ctl,
  output logic       grant,
  output logic       refuse,
  output logic       wr_en,
  output logic       rd_en,
  output logic       rd_req
);

  assign grant  = req && access_permitted(run_mode, tx_state, ctl);
  assign refuse = req && !grant;
  assign wr_en  = grant && we;
  assign rd_en  = grant && !we;
  assign rd_req = req && !we;

  // R1
  stop_mode_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !run_mode) |-> grant);

  // R2
  closed_state_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && (tx_state[2] || tx_state == 3'd2)) |-> !grant);

  // R3
  option_bits_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && !(ctl.itc && ctl.irr)) |-> !grant);

  // R4
  function_bits_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && (ctl.clm || ctl.bcn)) |-> !grant);

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en, refuse}));

endmodule

// File: rtl/pag_ram.sv
module pag_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic                         rd_req,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid,
  output logic [DEPTH-1:0][DATA_W-1:0] mem_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wdata;
    end
  end

  // every read completes after one cycle; refused reads return zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      rdata  <= rd_en ? mem_q[addr] : '0;
    end
  end

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(addr)] == $past(wdata));

  // R6
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

endmodule

// File: rtl/pag_err_flag.sv
module pag_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  // a set in the same cycle as a clear takes priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt) |=> flag == $past(flag));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag);

endmodule

// File: rtl/parm_access_guard.sv
module parm_access_guard
  import pag_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int LONG_BASE = 'h40,
  localparam int DEPTH       = 1 << ADDR_W,
  localparam int LONG_BYTES  = 6,
  localparam int SHORT_BYTES = 2,
  localparam int SHORT_BASE  = LONG_BASE + LONG_BYTES,
  localparam int LONG_W      = LONG_BYTES * DATA_W,
  localparam int SHORT_W     = SHORT_BYTES * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic               run_mode,
  input  logic [2:0]         tx_state,
  input  logic               opt_itc,
  input  logic               opt_irr,
  input  logic               fn_clm,
  input  logic               fn_bcn,
  input  logic               err_clr,
  output logic               cmd_err,
  output logic [LONG_W-1:0]  long_addr,
  output logic [SHORT_W-1:0] short_addr
);

  ctl_bits_t ctl;
  logic grant, refuse, wr_en, rd_en, rd_req;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  assign ctl = '{itc: opt_itc, irr: opt_irr, clm: fn_clm, bcn: fn_bcn};

  pag_permit u_permit (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (host_req),
    .we       (host_we),
    .run_mode (run_mode),
    .tx_state (tx_state),
    .ctl      (ctl),
    .grant    (grant),
    .refuse   (refuse),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_req   (rd_req)
  );

  pag_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rd_req (rd_req),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .rdata  (host_rdata),
    .rvalid (host_rvalid),
    .mem_q  (mem_q)
  );

  pag_err_flag u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (refuse),
    .clr_evt (err_clr),
    .flag    (cmd_err)
  );

  // station addresses: lowest offset is the most significant byte
  for (genvar i = 0; i < LONG_BYTES; i++) begin : g_long
    assign long_addr[LONG_W-1-i*DATA_W -: DATA_W] = mem_q[LONG_BASE+i];
  end
  for (genvar j = 0; j < SHORT_BYTES; j++) begin : g_short
    assign short_addr[SHORT_W-1-j*DATA_W -: DATA_W] = mem_q[SHORT_BASE+j];
  end

  // R5
  refused_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && !grant) |=> $stable(mem_q));

  // R6
  read_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);

  // R6
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && !grant) |=> host_rdata == '0);

  // R9
  long_msb_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && host_addr == ADDR_W'(LONG_BASE))
      |=> long_addr[LONG_W-1 -: DATA_W] == $past(host_wdata));

endmodule

// File: tb/parm_access_guard_tb_top.sv
module parm_access_guard_tb_top;

  localparam int AW = 7;
  localparam int DW = 8;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0, clr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic run_b = 0, itc_b = 0, irr_b = 0, clm_b = 0, bcn_b = 0;
  logic [2:0] st_b = 3'd0;
  logic [DW-1:0] rdata;
  logic rvalid, err;
  logic [47:0] long_a;
  logic [15:0] short_a;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int unsigned m_mem [NB];
  bit m_err;
  bit m_rvalid;
  int unsigned m_rdata;

  always #4 clk = ~clk;

  parm_access_guard dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .host_rvalid(rvalid), .run_mode(run_b), .tx_state(st_b),
    .opt_itc(itc_b), .opt_irr(irr_b), .fn_clm(clm_b), .fn_bcn(bcn_b),
    .err_clr(clr), .cmd_err(err), .long_addr(long_a), .short_addr(short_a)
  );

  function automatic bit model_ok();
    if (!run_b) return 1;
    if (!(st_b == 3'd0 || st_b == 3'd1 || st_b == 3'd3)) return 0;
    if (itc_b !== 1'b1 || irr_b !== 1'b1) return 0;
    if (clm_b !== 1'b0 || bcn_b !== 1'b0) return 0;
    return 1;
  endfunction

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    longint unsigned el, es;
    el = 0;
    for (int k = 0; k < 6; k++) el = (el << 8) | m_mem['h40 + k];
    es = (longint'(m_mem['h46]) << 8) | m_mem['h47];
    check(tag, "rvalid", rvalid, m_rvalid);
    check(tag, "rdata", rdata, m_rdata);
    check(tag, "cmd_err", err, m_err);
    check(tag, "long_addr", long_a, el);
    check(tag, "short_addr", short_a, es);
  endtask

  // drive one cycle at a falling edge, advance the model, compare after the rising edge
  task automatic step(input bit r, input bit w, input int a, input int d,
                      input bit c, input string tag);
    bit ok;
    req = r; we = w; addr = AW'(a); wdata = DW'(d); clr = c;
    ok = model_ok();
    m_rvalid = r && !w;
    m_rdata  = (r && !w && ok) ? m_mem[a] : 0;
    if (r && w && ok) m_mem[a] = d;
    if (r && !ok) m_err = 1;
    else if (c) m_err = 0;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic set_ctl(input bit run, input int st, input bit i1, input bit i2,
                         input bit f1, input bit f2);
    run_b = run; st_b = 3'(st); itc_b = i1; irr_b = i2; clm_b = f1; bcn_b = f2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NB; k++) m_mem[k] = 0;
    m_err = 0; m_rvalid = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    compare_all("R10");
    step(1, 0, 'h7F, 0, 0, "R10");

    // R1 stopped: control bits all in their blocking values
    set_ctl(0, 7, 0, 0, 1, 1);
    for (int k = 0; k < 8; k++) step(1, 1, 'h40 + k, 'h11 * (k + 1), 0, "R1");
    step(1, 1, 'h7F, 'hA5, 0, "R1");
    for (int k = 0; k < 8; k++) step(1, 0, 'h40 + k, 0, 0, "R9");
    step(1, 0, 'h7F, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");

    // R2 running with open control bits, each state code
    for (int s = 0; s < 8; s++) begin
      set_ctl(1, s, 1, 1, 0, 0);
      step(1, 1, 'h10 + s, 'h30 + s, 0, "R2");
      step(1, 0, 'h10 + s, 0, 0, "R2");
      step(1, 0, 'h40, 0, 0, "R5");
      step(0, 0, 0, 0, 1, "R8");
    end

    // R3 option bits
    set_ctl(1, 1, 0, 1, 0, 0);
    step(1, 1, 'h41, 'hEE, 0, "R3");
    set_ctl(1, 1, 1, 0, 0, 0);
    step(1, 0, 'h41, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R8 clear and refusal together
    step(1, 1, 'h42, 'h99, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");

    // R4 function bits
    set_ctl(1, 3, 1, 1, 1, 0);
    step(1, 1, 'h46, 'h5A, 0, "R4");
    set_ctl(1, 3, 1, 1, 0, 1);
    step(1, 0, 'h46, 0, 1, "R4");
    set_ctl(1, 3, 1, 1, 0, 0);
    step(1, 1, 'h46, 'h5A, 1, "R4");
    step(1, 0, 'h46, 0, 0, "R9");

    // R6 random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      a = ($urandom % 2) ? ('h40 + $urandom % 8) : ($urandom % NB);
      set_ctl($urandom % 2, $urandom % 8, ($urandom % 4) != 0, ($urandom % 4) != 0,
              ($urandom % 4) == 0, ($urandom % 4) == 0);
      step($urandom % 2, $urandom % 2, a, $urandom % 256, ($urandom % 8) == 0, "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule